// File: doc/BRIEF.md
# Hybrid Branch Direction and Target Predictor

This block predicts near branches for an instruction fetch pipeline. At fetch time the linear address of an instruction indexes a direct-mapped table whose entries hold a tag, a two-bit saturating direction counter and the last resolved target; a valid entry with a matching tag yields a registered prediction one clock later. Entries are written only from a retire-time port that carries the resolved outcome and target, and an entry missing at retire is allocated with a counter seeded from that outcome.

A second, decode-time port receives the kind of the decoded branch and the sign of its displacement. Conditional branches that find no valid entry fall back to a static rule: backward branches are taken, forward ones are not. Calls push their fall-through address onto a return address stack of sixteen circular entries, and returns pop it to predict their target. Far transfers (far calls and software interrupts) never receive a prediction.

Top module: `branch_predictor`

## Requirements
- R1: A fetch lookup presented in cycle N drives `lk_vld_o` in cycle N+1 high only when the indexed entry (index = address bits [5:0], tag = bits [31:6]) is valid with an equal tag; then `lk_taken_o` is the counter MSB (counter 2 or 3 means taken) and `lk_tgt_o` the stored target. With `lk_valid_i` low, `lk_vld_o` is low in the next cycle.
- R2: A tag mismatch at the indexed entry, or an entry never written since reset, counts as a miss (`lk_vld_o` low); a write by another address with the same index replaces the entry.
- R3: A retire update that misses allocates the entry with counter 2 when taken and 1 when not taken, and stores the resolved target.
- R4: A retire update that hits adds one to the counter when taken and subtracts one when not taken, saturating at 3 and 0, and overwrites the stored target.
- R5: When a lookup and a retire update use the same entry in the same cycle, the lookup result reflects the contents before the update.
- R6: A decoded conditional branch (type 0) with no valid entry is predicted statically: `dp_valid_o`=1, `dp_static_o`=1, `dp_taken_o`=`dec_back_i` (1 = negative displacement), `dp_tgt_o`=0.
- R7: A decoded conditional branch with a valid entry uses the counter and stored target, with `dp_static_o`=0.
- R8: A decoded call (type 1) pushes `dec_ret_addr_i`; a decoded return (type 2) pops, giving `dp_valid_o`=1, `dp_taken_o`=1 and `dp_tgt_o` equal to the most recent unpopped push.
- R9: The stack holds 16 addresses; a push onto a full stack overwrites the oldest, so after 17 pushes 16 pops return the newest 16 in reverse order and a 17th pop finds the stack empty.
- R10: A return decoded with an empty stack gives `dp_valid_o`=0 and leaves the stack empty.
- R11: A far transfer (type 4, or any type above 4) gives `dp_valid_o`=0 and neither pushes nor pops the stack.
- R12: Calls and indirect branches (type 3) give `dp_valid_o` equal to a valid entry hit, with `dp_taken_o`=1 and the stored target; a call pushes whether or not it hits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid_i | input | 1 | Fetch lookup request |
| lk_addr_i | input | 32 | Fetch linear address |
| lk_vld_o | output | 1 | Lookup found a valid entry (registered) |
| lk_taken_o | output | 1 | Predicted direction of the lookup |
| lk_tgt_o | output | 32 | Predicted target of the lookup |
| dec_valid_i | input | 1 | A branch was decoded this cycle |
| dec_addr_i | input | 32 | Linear address of the decoded branch |
| dec_type_i | input | 3 | 0 conditional, 1 call, 2 return, 3 indirect, 4 far |
| dec_back_i | input | 1 | Displacement is negative |
| dec_ret_addr_i | input | 32 | Fall-through address pushed by a call |
| dp_valid_o | output | 1 | Decode-time prediction is usable (registered) |
| dp_taken_o | output | 1 | Decode-time predicted direction |
| dp_tgt_o | output | 32 | Decode-time predicted target |
| dp_static_o | output | 1 | Prediction came from the displacement-sign rule |
| up_valid_i | input | 1 | Retire-time update |
| up_addr_i | input | 32 | Address of the retired branch |
| up_taken_i | input | 1 | Resolved direction |
| up_tgt_i | input | 32 | Resolved target |

## Verification
The counter is driven through runs of equal outcomes to reach both saturation points and then reversed, which separates a saturating counter from a wrapping one and shows the taken threshold sits between 1 and 2. Aliasing addresses that share an index but not a tag separate a tag compare from a plain index hit, and lookups issued in the very cycle of their own update separate pre-update from forwarded reads. Call/return sequences that overfill, drain and underflow the stack, interleaved with far transfers, separate circular overwrite from saturation and show far transfers leave the stack alone; a long random mix of all ports against a bench model covers the interactions.

// File: rtl/bp_pkg.sv
package bp_pkg;

  typedef enum logic [2:0] {
    BR_COND = 3'd0,
    BR_CALL = 3'd1,
    BR_RET  = 3'd2,
    BR_IND  = 3'd3,
    BR_FAR  = 3'd4
  } br_kind_e;

  // Saturating two-bit direction counter step.
  function automatic logic [1:0] ctr_step(input logic [1:0] cur, input logic tk);
    if (tk) return (cur == 2'd3) ? 2'd3 : cur + 2'd1;
    else    return (cur == 2'd0) ? 2'd0 : cur - 2'd1;
  endfunction

  // Weak state matching the first observed outcome.
  function automatic logic [1:0] ctr_seed(input logic tk);
    return tk ? 2'd2 : 2'd1;
  endfunction

  function automatic logic ctr_taken(input logic [1:0] cur);
    return cur[1];
  endfunction

  // Displacement-sign fallback: backward taken, forward not taken.
  function automatic logic static_dir(input logic backward);
    return backward;
  endfunction

endpackage

// File: rtl/bp_btb.sv
module bp_btb
  import bp_pkg::*;
#(
  parameter int AW      = 32,
  parameter int ENTRIES = 64,
  parameter int NRD     = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NRD-1:0][AW-1:0]  rd_addr_i,
  output logic [NRD-1:0]          rd_hit_o,
  output logic [NRD-1:0]          rd_taken_o,
  output logic [NRD-1:0][AW-1:0]  rd_tgt_o,
  input  logic                    up_en_i,
  input  logic [AW-1:0]           up_addr_i,
  input  logic                    up_taken_i,
  input  logic [AW-1:0]           up_tgt_i
);
  localparam int IW = $clog2(ENTRIES);
  localparam int TW = AW - IW;

  logic [ENTRIES-1:0] vld_q;
  logic [TW-1:0]      tag_q [ENTRIES];
  logic [1:0]         ctr_q [ENTRIES];
  logic [AW-1:0]      tgt_q [ENTRIES];

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    logic [IW-1:0] idx;
    assign idx           = rd_addr_i[p][IW-1:0];
    assign rd_hit_o[p]   = vld_q[idx] && (tag_q[idx] == rd_addr_i[p][AW-1:IW]);
    assign rd_taken_o[p] = ctr_taken(ctr_q[idx]);
    assign rd_tgt_o[p]   = tgt_q[idx];
  end

  // Named update events for the checks below.
  logic [IW-1:0] up_idx;
  logic [TW-1:0] up_tag;
  logic          up_hit;
  logic [1:0]    up_ctr_cur;
  logic [1:0]    up_ctr_new;
  assign up_idx     = up_addr_i[IW-1:0];
  assign up_tag     = up_addr_i[AW-1:IW];
  assign up_hit     = vld_q[up_idx] && (tag_q[up_idx] == up_tag);
  assign up_ctr_cur = ctr_q[up_idx];
  assign up_ctr_new = up_hit ? ctr_step(up_ctr_cur, up_taken_i) : ctr_seed(up_taken_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      for (int i = 0; i < ENTRIES; i++) begin
        tag_q[i] <= '0;
        ctr_q[i] <= '0;
        tgt_q[i] <= '0;
      end
    end else if (up_en_i) begin
      vld_q[up_idx] <= 1'b1;
      tag_q[up_idx] <= up_tag;
      ctr_q[up_idx] <= up_ctr_new;
      tgt_q[up_idx] <= up_tgt_i;
    end
  end

  // R3
  alloc_seed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    up_en_i && !up_hit |=> vld_q[$past(up_idx)] &&
      (ctr_q[$past(up_idx)] == ($past(up_taken_i) ? 2'd2 : 2'd1)));

  // R4
  ctr_top_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    up_en_i && up_hit && up_ctr_cur == 2'd3 && up_taken_i |=> ctr_q[$past(up_idx)] == 2'd3);

  // R4
  ctr_bot_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    up_en_i && up_hit && up_ctr_cur == 2'd0 && !up_taken_i |=> ctr_q[$past(up_idx)] == 2'd0);

endmodule

// File: rtl/bp_ras.sv
module bp_ras #(
  parameter int AW    = 32,
  parameter int DEPTH = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_i,
  input  logic [AW-1:0] push_addr_i,
  input  logic          pop_i,
  output logic          top_vld_o,
  output logic [AW-1:0] top_addr_o
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [AW-1:0] mem_q [DEPTH];
  logic [PW-1:0] ptr_q;
  logic [CW-1:0] cnt_q;

  function automatic logic [PW-1:0] ptr_inc(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  function automatic logic [PW-1:0] ptr_dec(input logic [PW-1:0] p);
    return (p == '0) ? PW'(DEPTH - 1) : p - PW'(1);
  endfunction

  logic          is_full;
  logic          is_empty;
  logic [PW-1:0] top_idx;
  assign is_full    = (cnt_q == CW'(DEPTH));
  assign is_empty   = (cnt_q == '0);
  assign top_idx    = ptr_dec(ptr_q);
  assign top_vld_o  = !is_empty;
  assign top_addr_o = mem_q[top_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
      cnt_q <= '0;
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (push_i) begin
      mem_q[ptr_q] <= push_addr_i;
      ptr_q        <= ptr_inc(ptr_q);
      if (!is_full) cnt_q <= cnt_q + CW'(1);
    end else if (pop_i && !is_empty) begin
      ptr_q <= top_idx;
      cnt_q <= cnt_q - CW'(1);
    end
  end

  // R9
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));

  // R9
  full_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push_i && is_full |=> is_full && $past(ptr_q) != ptr_q);

  // R10
  empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop_i && !push_i && is_empty |=> is_empty && $stable(ptr_q));

endmodule

// File: rtl/branch_predictor.sv
module branch_predictor
  import bp_pkg::*;
#(
  parameter int AW          = 32,
  parameter int BTB_ENTRIES = 64,
  parameter int RAS_DEPTH   = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          lk_valid_i,
  input  logic [AW-1:0] lk_addr_i,
  output logic          lk_vld_o,
  output logic          lk_taken_o,
  output logic [AW-1:0] lk_tgt_o,
  input  logic          dec_valid_i,
  input  logic [AW-1:0] dec_addr_i,
  input  logic [2:0]    dec_type_i,
  input  logic          dec_back_i,
  input  logic [AW-1:0] dec_ret_addr_i,
  output logic          dp_valid_o,
  output logic          dp_taken_o,
  output logic [AW-1:0] dp_tgt_o,
  output logic          dp_static_o,
  input  logic          up_valid_i,
  input  logic [AW-1:0] up_addr_i,
  input  logic          up_taken_i,
  input  logic [AW-1:0] up_tgt_i
);
  localparam int NRD    = 2;
  localparam int P_LOOK = 0;
  localparam int P_DEC  = 1;

  logic [NRD-1:0][AW-1:0] rd_addr;
  logic [NRD-1:0]         rd_hit;
  logic [NRD-1:0]         rd_taken;
  logic [NRD-1:0][AW-1:0] rd_tgt;

  assign rd_addr[P_LOOK] = lk_addr_i;
  assign rd_addr[P_DEC]  = dec_addr_i;

  bp_btb #(.AW(AW), .ENTRIES(BTB_ENTRIES), .NRD(NRD)) u_btb (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_addr_i  (rd_addr),
    .rd_hit_o   (rd_hit),
    .rd_taken_o (rd_taken),
    .rd_tgt_o   (rd_tgt),
    .up_en_i    (up_valid_i),
    .up_addr_i  (up_addr_i),
    .up_taken_i (up_taken_i),
    .up_tgt_i   (up_tgt_i)
  );

  br_kind_e      kind;
  logic          ras_push;
  logic          ras_pop;
  logic          ras_vld;
  logic [AW-1:0] ras_top;
  logic          is_far;

  assign kind     = br_kind_e'(dec_type_i);
  assign ras_push = dec_valid_i && (kind == BR_CALL);
  assign ras_pop  = dec_valid_i && (kind == BR_RET);
  assign is_far   = dec_type_i >= 3'd4;

  bp_ras #(.AW(AW), .DEPTH(RAS_DEPTH)) u_ras (
    .clk         (clk),
    .rst_n       (rst_n),
    .push_i      (ras_push),
    .push_addr_i (dec_ret_addr_i),
    .pop_i       (ras_pop),
    .top_vld_o   (ras_vld),
    .top_addr_o  (ras_top)
  );

  logic          dp_valid_d;
  logic          dp_taken_d;
  logic [AW-1:0] dp_tgt_d;
  logic          dp_static_d;

  always_comb begin
    dp_valid_d  = 1'b0;
    dp_taken_d  = 1'b0;
    dp_tgt_d    = '0;
    dp_static_d = 1'b0;
    if (dec_valid_i) begin
      unique case (kind)
        BR_COND: begin
          dp_valid_d = 1'b1;
          if (rd_hit[P_DEC]) begin
            dp_taken_d = rd_taken[P_DEC];
            dp_tgt_d   = rd_tgt[P_DEC];
          end else begin
            dp_taken_d  = static_dir(dec_back_i);
            dp_static_d = 1'b1;
          end
        end
        BR_CALL, BR_IND: begin
          dp_valid_d = rd_hit[P_DEC];
          dp_taken_d = 1'b1;
          dp_tgt_d   = rd_tgt[P_DEC];
        end
        BR_RET: begin
          dp_valid_d = ras_vld;
          dp_taken_d = 1'b1;
          dp_tgt_d   = ras_top;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lk_vld_o    <= 1'b0;
      lk_taken_o  <= 1'b0;
      lk_tgt_o    <= '0;
      dp_valid_o  <= 1'b0;
      dp_taken_o  <= 1'b0;
      dp_tgt_o    <= '0;
      dp_static_o <= 1'b0;
    end else begin
      lk_vld_o    <= lk_valid_i && rd_hit[P_LOOK];
      lk_taken_o  <= lk_valid_i && rd_hit[P_LOOK] && rd_taken[P_LOOK];
      lk_tgt_o    <= rd_tgt[P_LOOK];
      dp_valid_o  <= dp_valid_d;
      dp_taken_o  <= dp_taken_d;
      dp_tgt_o    <= dp_tgt_d;
      dp_static_o <= dp_static_d;
    end
  end

  // R11
  far_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid_i && is_far |=> !dp_valid_o);

  // R1
  lk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid_i |=> !lk_vld_o);

  // R6
  static_only_cond_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dp_static_o |-> dp_valid_o && $past(dec_valid_i && kind == BR_COND && !rd_hit[P_DEC]));

endmodule

// File: tb/test_branch_predictor.sv
module test_branch_predictor;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lk_valid_i = 1'b0;
  logic [31:0] lk_addr_i = '0;
  logic        lk_vld_o, lk_taken_o;
  logic [31:0] lk_tgt_o;
  logic        dec_valid_i = 1'b0;
  logic [31:0] dec_addr_i = '0;
  logic [2:0]  dec_type_i = '0;
  logic        dec_back_i = 1'b0;
  logic [31:0] dec_ret_addr_i = '0;
  logic        dp_valid_o, dp_taken_o, dp_static_o;
  logic [31:0] dp_tgt_o;
  logic        up_valid_i = 1'b0;
  logic [31:0] up_addr_i = '0;
  logic        up_taken_i = 1'b0;
  logic [31:0] up_tgt_i = '0;

  branch_predictor i_branch_predictor (
    .clk, .rst_n, .lk_valid_i, .lk_addr_i, .lk_vld_o, .lk_taken_o, .lk_tgt_o,
    .dec_valid_i, .dec_addr_i, .dec_type_i, .dec_back_i, .dec_ret_addr_i,
    .dp_valid_o, .dp_taken_o, .dp_tgt_o, .dp_static_o,
    .up_valid_i, .up_addr_i, .up_taken_i, .up_tgt_i
  );

  always #2ns clk = ~clk;

  int nchk = 0;
  int nerr = 0;
  int cyc  = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // Bench model of the requirements.
  bit          m_v   [64];
  logic [25:0] m_tag [64];
  logic [1:0]  m_ctr [64];
  logic [31:0] m_tgt [64];
  logic [31:0] m_stk [$];

  // Scoreboard queues.
  int          q_due [$];
  bit          q_dec [$];
  bit          q_vld [$];
  bit          q_tk  [$];
  logic [31:0] q_tg  [$];
  bit          q_st  [$];
  string       q_req [$];

  function automatic void expect_item(bit d, bit v, bit t, logic [31:0] g, bit s, string r);
    q_due.push_back(cyc + 1); q_dec.push_back(d); q_vld.push_back(v);
    q_tk.push_back(t); q_tg.push_back(g); q_st.push_back(s); q_req.push_back(r);
  endfunction

  function automatic bit m_hit(logic [31:0] a);
    return m_v[a[5:0]] && m_tag[a[5:0]] == a[31:6];
  endfunction

  // Monitor: compares outputs one cycle after each driven cycle.
  always @(negedge clk) begin
    while (q_due.size() > 0 && q_due[0] == cyc) begin
      bit d, v, t, s, bad;
      logic [31:0] g;
      string r;
      d = q_dec.pop_front(); v = q_vld.pop_front(); t = q_tk.pop_front();
      g = q_tg.pop_front(); s = q_st.pop_front(); r = q_req.pop_front();
      void'(q_due.pop_front());
      nchk++;
      if (d) begin
        bad = v ? (dp_valid_o !== 1'b1 || dp_taken_o !== t || dp_tgt_o !== g || dp_static_o !== s)
                : (dp_valid_o !== 1'b0);
        if (bad) begin
          nerr++;
          $display("FAIL %s decode: act v=%b t=%b tgt=%h st=%b exp v=%b t=%b tgt=%h st=%b",
                   r, dp_valid_o, dp_taken_o, dp_tgt_o, dp_static_o, v, t, g, s);
        end
      end else begin
        bad = v ? (lk_vld_o !== 1'b1 || lk_taken_o !== t || lk_tgt_o !== g)
                : (lk_vld_o !== 1'b0);
        if (bad) begin
          nerr++;
          $display("FAIL %s lookup: act v=%b t=%b tgt=%h exp v=%b t=%b tgt=%h",
                   r, lk_vld_o, lk_taken_o, lk_tgt_o, v, t, g);
        end
      end
    end
  end

  // Driver: one cycle on all three ports, expectations from the model.
  task automatic op(bit le, logic [31:0] la, bit ue, logic [31:0] ua, bit ut, logic [31:0] utg,
                    bit de, logic [31:0] da, logic [2:0] dty, bit dbk, logic [31:0] dra, string r);
    bit h;
    lk_valid_i = le; lk_addr_i = la;
    up_valid_i = ue; up_addr_i = ua; up_taken_i = ut; up_tgt_i = utg;
    dec_valid_i = de; dec_addr_i = da; dec_type_i = dty; dec_back_i = dbk; dec_ret_addr_i = dra;
    h = m_hit(la);
    expect_item(1'b0, le && h, m_ctr[la[5:0]][1], m_tgt[la[5:0]], 1'b0, r);
    h = m_hit(da);
    if (!de) expect_item(1'b1, 1'b0, 1'b0, '0, 1'b0, r);
    else case (dty)
      3'd0: if (h) expect_item(1'b1, 1'b1, m_ctr[da[5:0]][1], m_tgt[da[5:0]], 1'b0, r);
            else   expect_item(1'b1, 1'b1, dbk, '0, 1'b1, r);
      3'd1: begin
        expect_item(1'b1, h, 1'b1, m_tgt[da[5:0]], 1'b0, r);
        m_stk.push_back(dra);
        if (m_stk.size() > 16) void'(m_stk.pop_front());
      end
      3'd2: if (m_stk.size() > 0) expect_item(1'b1, 1'b1, 1'b1, m_stk.pop_back(), 1'b0, r);
            else expect_item(1'b1, 1'b0, 1'b0, '0, 1'b0, r);
      3'd3: expect_item(1'b1, h, 1'b1, m_tgt[da[5:0]], 1'b0, r);
      default: expect_item(1'b1, 1'b0, 1'b0, '0, 1'b0, r);
    endcase
    if (ue) begin
      if (m_hit(ua)) begin
        if (ut) m_ctr[ua[5:0]] = (m_ctr[ua[5:0]] == 2'd3) ? 2'd3 : m_ctr[ua[5:0]] + 2'd1;
        else    m_ctr[ua[5:0]] = (m_ctr[ua[5:0]] == 2'd0) ? 2'd0 : m_ctr[ua[5:0]] - 2'd1;
      end else begin
        m_ctr[ua[5:0]] = ut ? 2'd2 : 2'd1;
      end
      m_v[ua[5:0]] = 1'b1; m_tag[ua[5:0]] = ua[31:6]; m_tgt[ua[5:0]] = utg;
    end
    @(negedge clk);
  endtask

  task automatic lk(logic [31:0] a, string r);
    op(1, a, 0, '0, 0, '0, 0, '0, 3'd0, 0, '0, r);
  endtask
  task automatic up(logic [31:0] a, bit t, logic [31:0] g, string r);
    op(0, '0, 1, a, t, g, 0, '0, 3'd0, 0, '0, r);
  endtask
  task automatic dec(logic [31:0] a, logic [2:0] ty, bit bk, logic [31:0] ra, string r);
    op(0, '0, 0, '0, 0, '0, 1, a, ty, bk, ra, r);
  endtask

  function automatic void check_now(bit ok, string r, string what);
    nchk++;
    if (!ok) begin nerr++; $display("FAIL %s %s", r, what); end
  endfunction

  localparam logic [31:0] A_ADDR = 32'h0000_1004;
  localparam logic [31:0] B_ADDR = 32'h0000_2004;  // same index as A_ADDR, other tag
  localparam logic [31:0] C_ADDR = 32'h0000_3011;

  bit done = 1'b0;

  initial begin
    for (int i = 0; i < 64; i++) begin m_v[i] = 0; m_tag[i] = '0; m_ctr[i] = '0; m_tgt[i] = '0; end
    repeat (3) @(negedge clk);
    // Reset state, R1
    check_now(lk_vld_o === 1'b0 && dp_valid_o === 1'b0 && dp_static_o === 1'b0, "R1",
              $sformatf("reset outputs act lk=%b dp=%b st=%b exp 0 0 0", lk_vld_o, dp_valid_o, dp_static_o));
    rst_n = 1'b1;
    @(negedge clk);

    lk(A_ADDR, "R2");                        // never written -> miss
    up(A_ADDR, 1, 32'h0000_0800, "R3");      // allocate, counter 2
    lk(A_ADDR, "R3");                        // hit, taken, target 0x800
    lk(A_ADDR, "R1");
    op(0, '0, 0, '0, 0, '0, 0, '0, 3'd0, 0, '0, "R1"); // idle lookup port
    up(A_ADDR, 0, 32'h0000_0800, "R4");      // 2 -> 1
    lk(A_ADDR, "R4");                        // not taken
    up(A_ADDR, 0, 32'h0000_0800, "R4");      // 1 -> 0
    up(A_ADDR, 0, 32'h0000_0800, "R4");      // stays 0
    up(A_ADDR, 1, 32'h0000_0900, "R4");      // 0 -> 1
    lk(A_ADDR, "R4");                        // still not taken: saturated at 0
    up(A_ADDR, 1, 32'h0000_0900, "R4");      // 2
    up(A_ADDR, 1, 32'h0000_0900, "R4");      // 3
    up(A_ADDR, 1, 32'h0000_0900, "R4");      // stays 3
    up(A_ADDR, 0, 32'h0000_0900, "R4");      // 2
    lk(A_ADDR, "R4");                        // still taken: saturated at 3
    lk(B_ADDR, "R2");                        // alias, tag mismatch
    up(B_ADDR, 0, 32'h0000_0a00, "R2");      // replaces entry
    lk(A_ADDR, "R2");
    lk(B_ADDR, "R3");                        // weakly not taken, target 0xa00
    // Same-cycle lookup and update
    op(1, C_ADDR, 1, C_ADDR, 1, 32'h0000_0c00, 0, '0, 3'd0, 0, '0, "R5");
    lk(C_ADDR, "R5");
    op(1, C_ADDR, 1, C_ADDR, 0, 32'h0000_0d00, 0, '0, 3'd0, 0, '0, "R5");
    lk(C_ADDR, "R5");
    // Static fallback
    dec(32'h0000_4020, 3'd0, 1, '0, "R6");
    dec(32'h0000_4020, 3'd0, 0, '0, "R6");
    dec(B_ADDR, 3'd0, 1, '0, "R7");          // hit: counter says not taken
    dec(C_ADDR, 3'd0, 0, '0, "R7");
    // Calls and returns
    dec(32'h0000_5000, 3'd2, 0, '0, "R10");  // empty
    dec(32'h0000_5000, 3'd1, 0, 32'h0000_5005, "R8");
    dec(32'h0000_6000, 3'd1, 0, 32'h0000_6005, "R8");
    dec(32'h0000_7000, 3'd4, 0, 32'h0000_7005, "R11");
    dec(32'h0000_7000, 3'd6, 0, 32'h0000_7005, "R11");
    dec(32'h0000_6100, 3'd2, 0, '0, "R8");
    dec(32'h0000_5100, 3'd2, 0, '0, "R11");
    dec(32'h0000_5100, 3'd2, 0, '0, "R10");
    // Overflow
    for (int i = 0; i < 17; i++) dec(32'h0001_0000 + 32'(i * 64), 3'd1, 0, 32'h00A0_0000 + 32'(i), "R9");
    for (int i = 0; i < 17; i++) dec(32'h0002_0000, 3'd2, 0, '0, "R9");
    // Indirect and call with BTB content
    up(32'h0000_8008, 1, 32'h0000_9999, "R12");
    dec(32'h0000_8008, 3'd3, 0, '0, "R12");
    dec(32'h0000_8048, 3'd3, 0, '0, "R12");
    dec(32'h0000_8008, 3'd1, 0, 32'h0000_800d, "R12");
    dec(32'h0000_8100, 3'd2, 0, '0, "R12");
    // Random mix against the model
    for (int i = 0; i < 400; i++) begin
      logic [31:0] a1, a2, a3;
      a1 = {24'h0, 2'($urandom_range(0, 3)), 6'($urandom_range(0, 7))};
      a2 = {24'h0, 2'($urandom_range(0, 3)), 6'($urandom_range(0, 7))};
      a3 = {24'h0, 2'($urandom_range(0, 3)), 6'($urandom_range(0, 7))};
      op(1'($urandom), a1, 1'($urandom), a2, 1'($urandom), $urandom,
         1'($urandom), a3, 3'($urandom_range(0, 5)), 1'($urandom), $urandom, "R5");
    end
    op(0, '0, 0, '0, 0, '0, 0, '0, 3'd0, 0, '0, "R1");
    op(0, '0, 0, '0, 0, '0, 0, '0, 3'd0, 0, '0, "R1");
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nchk++; nerr++;
      $display("FAIL watchdog expired act running exp finished");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

endmodule